// File: doc/BRIEF.md
# Tachometer Speed Discriminator with Lock Detect

This block turns a motor's tachometer pulse train into the digital error words a speed servo loop needs. The clock is a crystal clock. A prescaler divides it into reference ticks, and each tachometer period is measured as a count of those ticks. At the target speed one period is 512 ticks long, so with the default prescaler of 16 the target pulse rate is the crystal frequency divided by 8192.

There are two error paths, and they run at different rates. The speed path adds two consecutive period counts and reports the signed distance of that sum from 1024 once for every two periods. The phase path runs a free-running reference counter that wraps every 512 ticks. At each tachometer rising edge it reports where that counter stands, as a signed offset from its rollover point. A lock flag, active low, is driven low while the averaged period stays within ±6.25% of the target. The drive loop uses the two error words to correct its duty cycle.

Top module: `fg_speed_servo`

## Requirements
- R1: While reset is held and on release, `lock_n_o` is 1, both valid strobes are 0, and `speed_err_o` is 0.
- R2: `speed_vld_o` pulses for exactly one cycle once for every two complete tachometer periods. A period is the interval between two rising edges of `fg_in`; high levels and falling edges are not counted.
- R3: When `speed_vld_o` is high, `speed_err_o` is the two's-complement value of (ticks in the earlier period + ticks in the later period − 1024). One tick is PRESCALE clocks, 16 by default.
- R4: `phase_vld_o` pulses once at each rising edge of `fg_in`. `phase_err_o` is the position of a free-running modulo-512 tick counter at that edge, read as a 9-bit two's-complement value (−256 to +255). For two consecutive edges, the difference of the results, wrapped modulo 512, equals the period length minus 512.
- R5: On each `speed_vld_o` pulse, `lock_n_o` becomes 0 if −64 ≤ `speed_err_o` ≤ +64 (that is, ±32 ticks per period) and becomes 1 otherwise. At any other time it changes only as R7 states.
- R6: After reset, the first rising edge only starts a measurement. No speed result and no lock is reported until two complete periods have been measured.
- R7: A period count stops at 1023 ticks and does not wrap. When the running count reaches 1023, `lock_n_o` goes to 1 on the next cycle, and the stalled period enters the speed sum as 1023.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal-derived clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fg_in | input | 1 | Asynchronous tachometer pulse input |
| speed_err_o | output | 11 | Signed two-period speed error in ticks |
| speed_vld_o | output | 1 | One-cycle strobe for `speed_err_o` |
| phase_err_o | output | 9 | Signed position of the edge against the reference rollover |
| phase_vld_o | output | 1 | One-cycle strobe for `phase_err_o` |
| lock_n_o | output | 1 | Low while speed is inside the lock window |

## Verification
The hardest case to reach is a period count that has saturated. For it to show up as a known value in a speed result, the stalled period has to fall in a known slot of the two-period pair, and the pair alignment cannot be seen at the ports. The stimulus reaches this case from a fresh reset with a single arming edge, followed by a silence of more than 1023 ticks and then one normal period, so the expected error is exactly 1023 + 512 − 1024 = 511. Lock release on a stall is checked separately, while the loop is locked, by holding the input low until the count saturates. Window edges are exercised at 544/545 and 480/470 ticks per period.

// File: rtl/fgs_pkg.sv
package fgs_pkg;
   // Pairing state of the period meter: waiting for the arming edge,
   // expecting the first period of a pair, or expecting the second one.
   typedef enum logic [1:0] {
      PAIR_WAIT   = 2'd0,
      PAIR_FIRST  = 2'd1,
      PAIR_SECOND = 2'd2
   } pair_state_e;
endpackage

// File: rtl/fgs_edge_sync.sv
module fgs_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);
   logic [STAGES-1:0] sr_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q   <= '0;
         last_q <= 1'b0;
      end else begin
         sr_q   <= {sr_q[STAGES-2:0], async_i};
         last_q <= sr_q[STAGES-1];
      end
   end

   // one-cycle pulse on a synchronized rising transition
   assign rise_o = sr_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/fgs_prescaler.sv
module fgs_prescaler #(
   parameter int DIV = 16
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   generate
      if (DIV == 1) begin : g_pass
         assign tick_o = 1'b1;
      end else begin : g_div
         localparam int PW = $clog2(DIV);
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         logic [PW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt_q <= '0;
            else if (cnt_q == LAST)  cnt_q <= '0;
            else                     cnt_q <= cnt_q + PW'(1);
         end

         assign tick_o = (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/fgs_period_meter.sv
module fgs_period_meter
   import fgs_pkg::*;
#(
   parameter int CNT_W     = 10,
   parameter int SAT_TICKS = 1023
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             edge_i,
   output logic [CNT_W:0]   pair_sum_o,
   output logic             pair_vld_o,
   output logic             stalled_o
);
   localparam logic [CNT_W-1:0] SAT_V = CNT_W'(SAT_TICKS);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] first_q;
   pair_state_e      st_q;
   logic             at_sat;

   assign at_sat = (cnt_q == SAT_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         first_q    <= '0;
         st_q       <= PAIR_WAIT;
         pair_sum_o <= '0;
         pair_vld_o <= 1'b0;
      end else begin
         pair_vld_o <= 1'b0;
         if (edge_i) begin
            // a tick coinciding with the edge belongs to the new period
            cnt_q <= tick_i ? CNT_W'(1) : '0;
            unique case (st_q)
               PAIR_WAIT:   st_q <= PAIR_FIRST;
               PAIR_FIRST: begin
                  first_q <= cnt_q;
                  st_q    <= PAIR_SECOND;
               end
               PAIR_SECOND: begin
                  pair_sum_o <= {1'b0, first_q} + {1'b0, cnt_q};
                  pair_vld_o <= 1'b1;
                  st_q       <= PAIR_FIRST;
               end
               default:     st_q <= PAIR_WAIT;
            endcase
         end else if (tick_i && !at_sat) begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

   assign stalled_o = at_sat;
endmodule

// File: rtl/fgs_phase_ref.sv
module fgs_phase_ref #(
   parameter int RW = 9
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_i,
   input  logic                 edge_i,
   output logic signed [RW-1:0] phase_o,
   output logic                 vld_o
);
   logic [RW-1:0] ref_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q   <= '0;
         phase_o <= '0;
         vld_o   <= 1'b0;
      end else begin
         if (tick_i) ref_q <= ref_q + RW'(1);
         vld_o <= edge_i;
         // modulo-2^RW position read as two's complement gives the
         // nearest signed distance from the rollover point
         if (edge_i) phase_o <= $signed(ref_q);
      end
   end
endmodule

// File: rtl/fg_speed_servo.sv
module fg_speed_servo #(
   parameter int PRESCALE    = 16,
   parameter int NOM_TICKS   = 512,
   parameter int LOCK_MARGIN = 32,
   parameter int SAT_TICKS   = 1023,
   parameter int SYNC_STAGES = 2,
   localparam int CNT_W = $clog2(SAT_TICKS + 1),
   localparam int SPD_W = CNT_W + 1,
   localparam int PH_W  = $clog2(NOM_TICKS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    fg_in,
   output logic signed [SPD_W-1:0] speed_err_o,
   output logic                    speed_vld_o,
   output logic signed [PH_W-1:0]  phase_err_o,
   output logic                    phase_vld_o,
   output logic                    lock_n_o
);
   localparam logic signed [SPD_W-1:0] WIN      = SPD_W'(2 * LOCK_MARGIN);
   localparam logic [SPD_W-1:0]        PAIR_NOM = SPD_W'(2 * NOM_TICKS);

   generate
      if (PRESCALE < 1) begin : g_bad_div
         $error("PRESCALE must be at least 1");
      end
      if ((NOM_TICKS & (NOM_TICKS - 1)) != 0) begin : g_bad_nom
         $error("NOM_TICKS must be a power of two");
      end
      if (SAT_TICKS <= NOM_TICKS + LOCK_MARGIN || SAT_TICKS >= 2 * NOM_TICKS) begin : g_bad_sat
         $error("SAT_TICKS must lie above the window and below twice nominal");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic               rise_w;
   logic               tick_w;
   logic [CNT_W:0]     pair_sum_w;
   logic               pair_vld_w;
   logic               stalled_w;
   logic signed [SPD_W-1:0] diff_w;
   logic               in_win_w;

   fgs_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (fg_in),
      .rise_o  (rise_w)
   );

   fgs_prescaler #(.DIV(PRESCALE)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick_w)
   );

   fgs_period_meter #(.CNT_W(CNT_W), .SAT_TICKS(SAT_TICKS)) u_meter (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick_w),
      .edge_i     (rise_w),
      .pair_sum_o (pair_sum_w),
      .pair_vld_o (pair_vld_w),
      .stalled_o  (stalled_w)
   );

   fgs_phase_ref #(.RW(PH_W)) u_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick_w),
      .edge_i  (rise_w),
      .phase_o (phase_err_o),
      .vld_o   (phase_vld_o)
   );

   assign diff_w   = $signed(pair_sum_w - PAIR_NOM);
   assign in_win_w = (diff_w >= -WIN) && (diff_w <= WIN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         speed_err_o <= '0;
         speed_vld_o <= 1'b0;
         lock_n_o    <= 1'b1;
      end else begin
         speed_vld_o <= pair_vld_w;
         if (pair_vld_w) speed_err_o <= diff_w;
         if (stalled_w)       lock_n_o <= 1'b1;
         else if (pair_vld_w) lock_n_o <= ~in_win_w;
      end
   end
endmodule

// File: rtl/fgs_servo_checker.sv
module fgs_servo_checker #(
   parameter int SPD_W   = 11,
   parameter int WIN     = 64,
   parameter int MAX_ERR = 1022
) (
   input logic             clk,
   input logic             rst_n,
   input logic [SPD_W-1:0] speed_err,
   input logic             speed_vld,
   input logic             phase_vld,
   input logic             lock_n,
   input logic             stalled
);
   // R2: the speed strobe is a single-cycle pulse
   a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      speed_vld |=> !speed_vld);

   // R2 / R4: every speed result follows the phase result of the same edge
   a_r2_after_phase: assert property (@(posedge clk) disable iff (!rst_n)
      speed_vld |-> $past(phase_vld));

   // R7: a saturated period bounds the largest reported error
   a_r7_err_bound: assert property (@(posedge clk) disable iff (!rst_n)
      speed_vld |-> ($signed(speed_err) <= MAX_ERR));

   // R5: entering lock only happens on an in-window speed result
   a_r5_lock_entry: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lock_n) |-> (speed_vld && $signed(speed_err) >= -WIN
                                   && $signed(speed_err) <= WIN));

   // R5 / R7: the lock flag moves only on a result or after a stall
   a_r5_lock_moves: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(lock_n) |-> (speed_vld || $past(stalled)));

   // R7: a saturated period count releases the lock
   a_r7_stall_release: assert property (@(posedge clk) disable iff (!rst_n)
      stalled |=> lock_n);
endmodule

bind fg_speed_servo fgs_servo_checker #(
   .SPD_W   (SPD_W),
   .WIN     (2 * LOCK_MARGIN),
   .MAX_ERR (2 * SAT_TICKS - 2 * NOM_TICKS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .speed_err (speed_err_o),
   .speed_vld (speed_vld_o),
   .phase_vld (phase_vld_o),
   .lock_n    (lock_n_o),
   .stalled   (stalled_w)
);

// File: tb/tb_fg_speed_servo.sv
module tb_fg_speed_servo;
   localparam int PS = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fg_in = 1'b0;
   logic signed [10:0] speed_err_o;
   logic               speed_vld_o;
   logic signed [8:0]  phase_err_o;
   logic               phase_vld_o;
   logic               lock_n_o;

   int checks = 0;
   int errors = 0;
   int nspeed = 0;
   int nphase = 0;
   int last_speed = 0;
   int last_phase = 0;
   int prev_phase = 0;

   always #5 clk = ~clk;

   fg_speed_servo #(.PRESCALE(PS)) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .fg_in       (fg_in),
      .speed_err_o (speed_err_o),
      .speed_vld_o (speed_vld_o),
      .phase_err_o (phase_err_o),
      .phase_vld_o (phase_vld_o),
      .lock_n_o    (lock_n_o)
   );

   // result monitor, sampled away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (speed_vld_o) begin
            last_speed = int'(speed_err_o);
            nspeed++;
         end
         if (phase_vld_o) begin
            prev_phase = last_phase;
            last_phase = int'(phase_err_o);
            nphase++;
         end
      end
   end

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      fg_in = 1'b0;
      repeat (4) @(negedge clk);
      nspeed = 0; nphase = 0; last_speed = 0; last_phase = 0; prev_phase = 0;
      chk("R1 lock_n in reset", int'(lock_n_o), 1);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // n tachometer periods of the given tick length, 50% duty
   task automatic run_fg(int ticks, int n);
      for (int i = 0; i < n; i++) begin
         fg_in = 1'b1;
         repeat (ticks * PS / 2) @(negedge clk);
         fg_in = 1'b0;
         repeat (ticks * PS - ticks * PS / 2) @(negedge clk);
      end
   endtask

   function automatic int wrap_diff(int a, int b);
      int d;
      d = ((a - b) % 512 + 512) % 512;
      if (d >= 256) d -= 512;
      return d;
   endfunction

   task automatic t_reset_state();
      do_reset();
      chk("R1 lock_n after reset", int'(lock_n_o), 1);
      chk("R1 speed_vld after reset", int'(speed_vld_o), 0);
      chk("R1 phase_vld after reset", int'(phase_vld_o), 0);
      chk("R1 speed_err after reset", int'(speed_err_o), 0);
   endtask

   task automatic t_startup();
      run_fg(512, 2);   // arming edge plus one complete period
      chk("R6 no speed result after one period", nspeed, 0);
      chk("R6 lock_n after one period", int'(lock_n_o), 1);
      chk("R4 phase result per edge", nphase, 2);
      run_fg(512, 1);   // closes the second period
      chk("R6 first speed result after two periods", nspeed, 1);
      chk("R3 nominal speed error", last_speed, 0);
      chk("R5 locked at nominal", int'(lock_n_o), 0);
   endtask

   // R2: six rising edges give three speed results, only rising edges count
   task automatic t_rate();
      int s0, p0;
      s0 = nspeed; p0 = nphase;
      run_fg(512, 6);
      chk("R2 speed results per six periods", nspeed - s0, 3);
      chk("R4 phase results per six periods", nphase - p0, 6);
      chk("R4 phase drift at nominal", wrap_diff(last_phase, prev_phase), 0);
   endtask

   task automatic t_speed(int ticks, int exp_lock_n, string tag);
      run_fg(ticks, 6);
      chk({tag, " speed error R3"}, last_speed, 2 * (ticks - 512));
      chk({tag, " lock R5"}, int'(lock_n_o), exp_lock_n);
      chk({tag, " phase step R4"}, wrap_diff(last_phase, prev_phase), ticks - 512);
   endtask

   task automatic t_stall_unlock();
      run_fg(512, 6);
      chk("R5 relocked before stall", int'(lock_n_o), 0);
      repeat (1100 * PS) @(negedge clk);
      chk("R7 stall releases lock", int'(lock_n_o), 1);
   endtask

   task automatic t_saturate();
      do_reset();
      run_fg(512, 1);                  // arming edge
      repeat (1100 * PS) @(negedge clk);
      run_fg(512, 1);                  // closes the stalled period
      run_fg(512, 1);                  // closes a nominal period
      chk("R7 saturated pair count", nspeed, 1);
      chk("R7 saturated speed error", last_speed, 1023 + 512 - 1024);
      chk("R7 lock_n after saturated pair", int'(lock_n_o), 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_reset_state();
      t_startup();
      t_rate();
      t_speed(540, 0, "slow in window");
      t_speed(544, 0, "upper edge");
      t_speed(545, 1, "just above window");
      t_speed(480, 0, "lower edge");
      t_speed(470, 1, "fast out of window");
      t_stall_unlock();
      t_saturate();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule